// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This unit sits inside one channel of a descriptor-driven DMA engine. When the channel finishes the work of a descriptor, the unit decides three things from that descriptor's command word. It decides whether to hold the descriptor in a wait, whether to raise an interrupt, and where the command pointer goes next. The next location is either the following descriptor, 16 bytes on, or a branch target taken from the descriptor's 32-bit dependent field.

All three decisions use one comparison rule. Each decision has its own select register. The select register holds a 4-bit mask in bits 19:16 and a 4-bit match value in bits 3:0. These are compared with the channel's four device-status bits. A 2-bit mode field per decision then chooses never, on a true condition, on a false condition, or always.

A wait decision is combinational, so the surrounding channel can hold off completion in the same cycle. Interrupt and pointer results are registered and appear one cycle after the evaluation strobe. The unit keeps the branch-taken status bit in step with each completed descriptor.

Top module: `dma_cond_eval`

## Requirements
- R1: The condition for a decision is true exactly when (dev_status AND mask) equals (value AND mask). The mask is bits 19:16 of that decision's select register and the value is bits 3:0. All other select bits are ignored.
- R2: Mode encoding is the same for all three decisions: 0 = never, 1 = when the condition is true, 2 = when the condition is false, 3 = always.
- R3: wait_hold is high in the same cycle as eval_valid exactly when the wait decision fires.
- R4: An evaluation that waits produces no irq_pulse and no ptr_update in the next cycle, and branch_taken keeps its value.
- R5: A completed evaluation whose branch decision fires gives ptr_update=1 and next_ptr=dep_field one cycle later, and sets branch_taken to 1.
- R6: A completed evaluation whose branch decision does not fire gives ptr_update=1 and next_ptr=cur_ptr+16 one cycle later, and clears branch_taken to 0.
- R7: irq_pulse is high for exactly one cycle, the cycle after a completed evaluation whose interrupt decision fires.
- R8: The interrupt, wait and branch decisions each use only their own select register.
- R9: After reset, irq_pulse, ptr_update and branch_taken are 0 and next_ptr is 0.
- R10: In a cycle after one without eval_valid, irq_pulse and ptr_update are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_valid | input | 1 | Evaluate the current descriptor this cycle |
| irq_mode | input | 2 | Interrupt mode field of the command |
| wait_mode | input | 2 | Wait mode field of the command |
| br_mode | input | 2 | Branch mode field of the command |
| dev_status | input | 4 | Channel device-status bits |
| irq_sel | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| wait_sel | input | 32 | Wait select register (mask 19:16, value 3:0) |
| br_sel | input | 32 | Branch select register (mask 19:16, value 3:0) |
| cur_ptr | input | 32 | Current command pointer |
| dep_field | input | 32 | Descriptor dependent field (branch target) |
| wait_hold | output | 1 | Descriptor must be retried, not completed |
| irq_pulse | output | 1 | One-cycle interrupt request |
| ptr_update | output | 1 | next_ptr is valid this cycle |
| next_ptr | output | 32 | New command pointer |
| branch_taken | output | 1 | Branch-taken status bit |

## Verification
On every cycle, the assertions check four things. A waiting evaluation changes neither the pointer, the interrupt nor the branch-taken bit. An idle cycle leaves both registered strobes low. The next pointer matches the branch target or the sequential step, according to branch_taken. A "never" mode cannot fire. The bench scenarios cover the rest: the masked comparison against all three select registers with junk in the unused bits, all four modes, and a branch-taken bit that persists across waits.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

    localparam int STAT_W   = 4;
    localparam int SEL_W    = 32;
    localparam int MASK_LSB = 16;
    localparam int N_DEC    = 3;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cond_mode_e;

    // decision slots
    localparam int DEC_IRQ  = 0;
    localparam int DEC_WAIT = 1;
    localparam int DEC_BR   = 2;

    function automatic logic sel_match(input logic [STAT_W-1:0] st,
                                       input logic [SEL_W-1:0]  sel);
        logic [STAT_W-1:0] msk;
        logic [STAT_W-1:0] val;
        msk = sel[MASK_LSB +: STAT_W];
        val = sel[STAT_W-1:0];
        return (st & msk) == (val & msk);
    endfunction

    function automatic logic mode_fire(input cond_mode_e m, input logic c);
        case (m)
            MODE_NEVER:    return 1'b0;
            MODE_IF_TRUE:  return c;
            MODE_IF_FALSE: return !c;
            default:       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dma_cond_unit.sv
module dma_cond_unit
    import dma_cond_pkg::*;
(
    input  logic [STAT_W-1:0] dev_status,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        mode,
    output logic              fire
);
    logic       cond;
    cond_mode_e m;

    always_comb begin
        m    = cond_mode_e'(mode);
        cond = sel_match(dev_status, sel);
        fire = mode_fire(m, cond);
    end

    // R2: a never mode cannot fire
    always_comb begin
        if (mode == 2'd0) begin
            assert_never_silent_R2: assert (!fire);
        end
    end
endmodule

// File: rtl/dma_cond_seq.sv
module dma_cond_seq #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_valid,
    input  logic              irq_fire,
    input  logic              wait_fire,
    input  logic              br_fire,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] dep_field,
    output logic              irq_pulse,
    output logic              ptr_update,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              branch_taken
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic complete;
    assign complete = eval_valid && !wait_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse    <= 1'b0;
            ptr_update   <= 1'b0;
            next_ptr     <= '0;
            branch_taken <= 1'b0;
        end else begin
            irq_pulse  <= complete && irq_fire;
            ptr_update <= complete;
            if (complete) begin
                branch_taken <= br_fire;
                next_ptr     <= br_fire ? dep_field : cur_ptr + STEP;
            end
        end
    end

    assert_wait_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && wait_fire) |=> (!irq_pulse && !ptr_update));

    assert_wait_keeps_bt_R4: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && wait_fire) |=> $stable(branch_taken));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !eval_valid |=> (!irq_pulse && !ptr_update));

    assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr_update && branch_taken) |-> (next_ptr == $past(dep_field)));

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ptr_update && !branch_taken) |-> (next_ptr == $past(cur_ptr) + STEP));
endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
    import dma_cond_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_valid,
    input  logic [1:0]        irq_mode,
    input  logic [1:0]        wait_mode,
    input  logic [1:0]        br_mode,
    input  logic [3:0]        dev_status,
    input  logic [31:0]       irq_sel,
    input  logic [31:0]       wait_sel,
    input  logic [31:0]       br_sel,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] dep_field,
    output logic              wait_hold,
    output logic              irq_pulse,
    output logic              ptr_update,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              branch_taken
);
    logic [SEL_W-1:0] sel_arr  [N_DEC];
    logic [1:0]       mode_arr [N_DEC];
    logic [N_DEC-1:0] fire;

    assign sel_arr[DEC_IRQ]   = irq_sel;
    assign sel_arr[DEC_WAIT]  = wait_sel;
    assign sel_arr[DEC_BR]    = br_sel;
    assign mode_arr[DEC_IRQ]  = irq_mode;
    assign mode_arr[DEC_WAIT] = wait_mode;
    assign mode_arr[DEC_BR]   = br_mode;

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        dma_cond_unit u_unit (
            .dev_status (dev_status),
            .sel        (sel_arr[g]),
            .mode       (mode_arr[g]),
            .fire       (fire[g])
        );
    end

    assign wait_hold = eval_valid && fire[DEC_WAIT];

    dma_cond_seq #(
        .ADDR_W     (ADDR_W),
        .DESC_BYTES (DESC_BYTES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .eval_valid   (eval_valid),
        .irq_fire     (fire[DEC_IRQ]),
        .wait_fire    (fire[DEC_WAIT]),
        .br_fire      (fire[DEC_BR]),
        .cur_ptr      (cur_ptr),
        .dep_field    (dep_field),
        .irq_pulse    (irq_pulse),
        .ptr_update   (ptr_update),
        .next_ptr     (next_ptr),
        .branch_taken (branch_taken)
    );
endmodule

// File: tb/dma_cond_eval_tb_top.sv
module dma_cond_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        eval_valid;
    logic [1:0]  irq_mode, wait_mode, br_mode;
    logic [3:0]  dev_status;
    logic [31:0] irq_sel, wait_sel, br_sel, cur_ptr, dep_field;
    logic        wait_hold, irq_pulse, ptr_update, branch_taken;
    logic [31:0] next_ptr;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_bt  = 1'b0;

    always #2 clk = ~clk;

    dma_cond_eval dut_i (
        .clk(clk), .rst(rst), .eval_valid(eval_valid),
        .irq_mode(irq_mode), .wait_mode(wait_mode), .br_mode(br_mode),
        .dev_status(dev_status), .irq_sel(irq_sel), .wait_sel(wait_sel),
        .br_sel(br_sel), .cur_ptr(cur_ptr), .dep_field(dep_field),
        .wait_hold(wait_hold), .irq_pulse(irq_pulse), .ptr_update(ptr_update),
        .next_ptr(next_ptr), .branch_taken(branch_taken)
    );

    function automatic bit m_cond(input logic [3:0] st, input logic [31:0] sel);
        return (st & sel[19:16]) == (sel[3:0] & sel[19:16]);
    endfunction

    function automatic bit m_fire(input logic [1:0] m, input bit c);
        case (m)
            2'd0: return 1'b0;
            2'd1: return c;
            2'd2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one evaluation; called at a negedge, returns at the next negedge
    task automatic run_eval(input logic [1:0] im, input logic [1:0] wm,
                            input logic [1:0] bm, input logic [3:0] st,
                            input logic [31:0] is, input logic [31:0] ws,
                            input logic [31:0] bs, input logic [31:0] cp,
                            input logic [31:0] dp);
        bit w, i, b;
        w = m_fire(wm, m_cond(st, ws));
        i = m_fire(im, m_cond(st, is));
        b = m_fire(bm, m_cond(st, bs));
        eval_valid = 1'b1; irq_mode = im; wait_mode = wm; br_mode = bm;
        dev_status = st; irq_sel = is; wait_sel = ws; br_sel = bs;
        cur_ptr = cp; dep_field = dp;
        #1;
        chk(wait_hold == w, "R3 wait_hold", 32'(wait_hold), 32'(w));
        @(posedge clk);
        @(negedge clk);
        eval_valid = 1'b0;
        if (w) begin
            chk(!irq_pulse && !ptr_update, "R4 wait suppresses",
                {30'd0, irq_pulse, ptr_update}, 32'd0);
            chk(branch_taken == exp_bt, "R4 bt kept", 32'(branch_taken), 32'(exp_bt));
        end else begin
            exp_bt = b;
            chk(irq_pulse == i, "R7/R2/R1 irq", 32'(irq_pulse), 32'(i));
            chk(ptr_update == 1'b1, "R5/R6 ptr_update", 32'(ptr_update), 32'd1);
            chk(branch_taken == b, "R5/R6 branch_taken", 32'(branch_taken), 32'(b));
            chk(next_ptr == (b ? dp : cp + 32'd16), "R5/R6 next_ptr",
                next_ptr, b ? dp : cp + 32'd16);
        end
    endtask

    task automatic idle_check();
        @(posedge clk);
        @(negedge clk);
        chk(!irq_pulse && !ptr_update, "R7/R10 idle", {30'd0, irq_pulse, ptr_update}, 32'd0);
        chk(branch_taken == exp_bt, "R10 bt stable", 32'(branch_taken), 32'(exp_bt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; eval_valid = 1'b0;
        irq_mode = 0; wait_mode = 0; br_mode = 0; dev_status = 0;
        irq_sel = 0; wait_sel = 0; br_sel = 0; cur_ptr = 0; dep_field = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(!irq_pulse && !ptr_update && !branch_taken, "R9 reset flags",
            {29'd0, irq_pulse, ptr_update, branch_taken}, 32'd0);
        chk(next_ptr == 32'd0, "R9 reset next_ptr", next_ptr, 32'd0);

        // R1: zero mask -> condition true; if-false never fires, junk bits ignored
        run_eval(2'd2, 2'd0, 2'd1, 4'hA, 32'hFFF0_FFF5, 32'h0, 32'h0000_0003,
                 32'h0000_1000, 32'h0000_8000);
        // R1: full mask, exact match vs mismatch; R8 each sel on its own
        run_eval(2'd1, 2'd0, 2'd2, 4'h6, 32'h000F_0006, 32'h000F_0009, 32'h000F_0006,
                 32'h0000_2000, 32'h0000_4440);
        // R2 always irq, never branch
        run_eval(2'd3, 2'd0, 2'd0, 4'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'h1234_5670);
        // R4: wait always, bt must hold (currently 0), then branch always to set bt
        run_eval(2'd3, 2'd3, 2'd3, 4'h1, 32'h0, 32'h0, 32'h0, 32'h100, 32'h200);
        run_eval(2'd3, 2'd0, 2'd3, 4'h1, 32'h0, 32'h0, 32'h0, 32'h100, 32'hABC0);
        // R4: wait-if-true with bt = 1 held
        run_eval(2'd3, 2'd1, 2'd2, 4'h3, 32'h0, 32'h0003_0003, 32'h0, 32'h300, 32'h400);
        // R8: wait sel mismatching while irq sel matches
        run_eval(2'd1, 2'd1, 2'd2, 4'h5, 32'h0005_0005, 32'h0001_0000, 32'h0005_0005,
                 32'h500, 32'h600);
        idle_check();

        for (int k = 0; k < 400; k++) begin
            run_eval(2'($urandom), 2'($urandom), 2'($urandom), 4'($urandom),
                     $urandom, $urandom, $urandom, $urandom & 32'hFFFF_FFF0, $urandom);
            if ((k % 7) == 0) idle_check();
        end
        idle_check();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule